// File: doc/BRIEF.md
# Asynchronous NAND Strobe Sequencer

This block turns single-byte requests into timed bus cycles on an 8-bit asynchronous NAND flash device. Each request says whether it is a read or a write, carries a byte for writes, and may mark the byte as a command or as an address. The block then walks through three access phases: setup, strobe and hold. After them it inserts a quiet gap. During these phases it drives the device select, the read and write strobes, the command-latch and address-latch qualifiers and the data-bus enable.

All phase durations come from one 32-bit timing word held in a register. Reads and writes each have their own setup, strobe and hold counts. A single gap count applies to both. A phase with field value N lasts N+1 clock cycles. A read returns its byte with a one-cycle response pulse. The device's ready/busy line is synchronised into a status bit.

Top module: `nand_strobe_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready`=1, `nand_sel_n`=1, `nand_rd_n`=1, `nand_wr_n`=1, `nand_cmd_latch`=0, `nand_addr_latch`=0, `nand_dq_oe`=0, `rsp_valid`=0 and `stat_ready`=0.
- R2: Timing word fields: write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4], gap [3:2]. After reset the word is 0x0432229C: write 1/3/1, read 1/5/1, gap 3. A `cfg_we` pulse loads `cfg_wdata` at the clock edge. The new word applies to any request accepted after that edge.
- R3: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. From the next cycle, setup lasts setup+1 cycles, strobe lasts strobe+1 and hold lasts hold+1. A read uses the read fields and a write uses the write fields.
- R4: `nand_sel_n` is 0 for all of setup, strobe and hold, and 1 otherwise. During the strobe phase only, `nand_rd_n` is 0 for a read or `nand_wr_n` is 0 for a write. The two strobes are never low together.
- R5: A read samples `nand_dq_in` at the edge that ends the last strobe cycle. The sampled byte appears on `rsp_rdata` with `rsp_valid`=1 for exactly the first hold cycle.
- R6: With `req_cmd`=1, `nand_cmd_latch` is 1 for the whole access window. With `req_addr`=1 and `req_cmd`=0, `nand_addr_latch` is 1 for the whole window. If both flags are set, only the command qualifier rises. Both qualifiers are 0 outside the window.
- R7: During a write, `nand_dq_oe`=1 and `nand_dq_out` equals the request byte from the first setup cycle to the last hold cycle. During reads, the gap and idle, `nand_dq_oe`=0 and `nand_dq_out`=0.
- R8: After hold, gap+1 cycles follow with select and both strobes high. `req_ready` is 0 from acceptance until the gap ends and returns to 1 on the following cycle.
- R9: `stat_ready` equals the value `nand_rb` (1 = device ready) had two clock edges earlier.
- R10: Bits 31, 30, 1 and 0 of the timing word have no effect on any access. The strobe-mode and wait-enable bits are treated as zero, and the bus is always 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the timing word |
| cfg_wdata | input | 32 | New timing word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 8 | Byte to write |
| req_cmd | input | 1 | Byte is a command |
| req_addr | input | 1 | Byte is an address |
| rsp_valid | output | 1 | Read byte valid (one cycle) |
| rsp_rdata | output | 8 | Read byte |
| nand_sel_n | output | 1 | Device select, active low |
| nand_rd_n | output | 1 | Read strobe, active low |
| nand_wr_n | output | 1 | Write strobe, active low |
| nand_cmd_latch | output | 1 | Command-latch qualifier |
| nand_addr_latch | output | 1 | Address-latch qualifier |
| nand_dq_out | output | 8 | Data bus value to drive |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus value from the device |
| nand_rb | input | 1 | Device ready/busy line |
| stat_ready | output | 1 | Synchronised ready status |

## Verification
The assertions assume that `req_rd`, `req_cmd`, `req_addr` and `req_wdata` are meaningful only on the accepting edge. They also assume that `cfg_we` is not pulsed in the same cycle a request is accepted. The stimulus meets both conditions. It raises `req_valid` for a single cycle while `req_ready` is high and writes the timing word only while the sequencer is idle. It drives `nand_dq_in` steady for the whole of a read, so the captured byte does not depend on when within the strobe it was sampled.

// File: rtl/nss_pkg.sv
package nss_pkg;

  localparam int CFG_W = 32;
  localparam int CNT_W = 6;
  localparam logic [CFG_W-1:0] CFG_DEFAULT = 32'h0432_229C;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_t;

  typedef struct packed {
    logic [3:0] wr_setup;
    logic [5:0] wr_strobe;
    logic [2:0] wr_hold;
    logic [3:0] rd_setup;
    logic [5:0] rd_strobe;
    logic [2:0] rd_hold;
    logic [1:0] gap;
  } timing_t;

  // Field extraction; bits 31,30,1,0 carry no timing.
  function automatic timing_t unpack_timing(input logic [29:2] w);
    timing_t t;
    t.wr_setup  = w[29:26];
    t.wr_strobe = w[25:20];
    t.wr_hold   = w[19:17];
    t.rd_setup  = w[16:13];
    t.rd_strobe = w[12:7];
    t.rd_hold   = w[6:4];
    t.gap       = w[3:2];
    return t;
  endfunction

  // Counter load values: a phase with load N lasts N+1 cycles.
  function automatic logic [CNT_W-1:0] setup_load(input timing_t t, input logic rd);
    return rd ? CNT_W'(t.rd_setup) : CNT_W'(t.wr_setup);
  endfunction

  function automatic logic [CNT_W-1:0] strobe_load(input timing_t t, input logic rd);
    return rd ? CNT_W'(t.rd_strobe) : CNT_W'(t.wr_strobe);
  endfunction

  function automatic logic [CNT_W-1:0] hold_load(input timing_t t, input logic rd);
    return rd ? CNT_W'(t.rd_hold) : CNT_W'(t.wr_hold);
  endfunction

  function automatic logic in_window(input phase_t p);
    return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD);
  endfunction

endpackage

// File: rtl/nss_cfg_reg.sv
module nss_cfg_reg
  import nss_pkg::*;
#(
  parameter int          WORD_W    = CFG_W,
  parameter logic [31:0] RESET_VAL = CFG_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output timing_t           timing
);

  localparam int FIELD_HI = 29;
  localparam int FIELD_LO = 2;

  logic [FIELD_HI:FIELD_LO] field_q;
  logic                     unused_ctl;

  // Strobe-mode, wait-enable and bus-size bits are fixed; they are not stored.
  assign unused_ctl = ^{cfg_wdata[WORD_W-1:FIELD_HI+1], cfg_wdata[FIELD_LO-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)      field_q <= RESET_VAL[FIELD_HI:FIELD_LO];
    else if (cfg_we) field_q <= cfg_wdata[FIELD_HI:FIELD_LO];
  end

  assign timing = unpack_timing(field_q);

endmodule

// File: rtl/nss_sequencer.sv
module nss_sequencer
  import nss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  timing_t           timing,
  input  logic              req_valid,
  input  logic              req_rd,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_cmd,
  input  logic              req_addr,
  output logic              req_ready,
  input  logic [DATA_W-1:0] dq_in,
  output phase_t            phase,
  output logic              acc_rd,
  output logic              acc_cmd,
  output logic              acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              acc_start,
  output logic              strobe_last,
  output logic              turn_done
);

  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stb_q, hold_q, gap_q;
  logic             cnt_zero;

  assign cnt_zero    = (cnt_q == '0);
  assign req_ready   = (ph_q == PH_IDLE);
  assign acc_start   = req_valid && req_ready;
  assign strobe_last = (ph_q == PH_STROBE) && cnt_zero;
  assign turn_done   = (ph_q == PH_TURN) && cnt_zero;
  assign phase       = ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      stb_q     <= '0;
      hold_q    <= '0;
      gap_q     <= '0;
      acc_rd    <= 1'b0;
      acc_cmd   <= 1'b0;
      acc_addr  <= 1'b0;
      acc_wdata <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (acc_start) begin
          ph_q      <= PH_SETUP;
          cnt_q     <= setup_load(timing, req_rd);
          stb_q     <= strobe_load(timing, req_rd);
          hold_q    <= hold_load(timing, req_rd);
          gap_q     <= CNT_W'(timing.gap);
          acc_rd    <= req_rd;
          acc_cmd   <= req_cmd;
          acc_addr  <= req_addr && !req_cmd;
          acc_wdata <= req_wdata;
        end
        PH_SETUP: if (cnt_zero) begin
          ph_q  <= PH_STROBE;
          cnt_q <= stb_q;
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (cnt_zero) begin
          ph_q  <= PH_HOLD;
          cnt_q <= hold_q;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_zero) begin
          ph_q  <= PH_TURN;
          cnt_q <= gap_q;
        end else cnt_q <= cnt_q - 1'b1;
        PH_TURN: if (cnt_zero) ph_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= strobe_last && acc_rd;
      if (strobe_last && acc_rd) rsp_rdata <= dq_in;
    end
  end

endmodule

// File: rtl/nss_pin_drive.sv
module nss_pin_drive
  import nss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  phase_t            phase,
  input  logic              acc_rd,
  input  logic              acc_cmd,
  input  logic              acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              sel_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              cmd_latch,
  output logic              addr_latch,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out
);

  logic win, strobing;

  always_comb begin
    win        = in_window(phase);
    strobing   = (phase == PH_STROBE);
    sel_n      = !win;
    rd_n       = !(strobing && acc_rd);
    wr_n       = !(strobing && !acc_rd);
    cmd_latch  = win && acc_cmd;
    addr_latch = win && acc_addr;
    dq_oe      = win && !acc_rd;
    dq_out     = dq_oe ? acc_wdata : '0;
  end

endmodule

// File: rtl/nss_rb_sync.sv
module nss_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nss_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] CFG_RESET   = CFG_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rd,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_cmd,
  input  logic              req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              nand_sel_n,
  output logic              nand_rd_n,
  output logic              nand_wr_n,
  output logic              nand_cmd_latch,
  output logic              nand_addr_latch,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb,
  output logic              stat_ready
);

  timing_t           timing;
  phase_t            phase;
  logic              acc_rd, acc_cmd, acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic              acc_start, strobe_last, turn_done;

  nss_cfg_reg #(.WORD_W(CFG_W), .RESET_VAL(CFG_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .timing(timing)
  );

  nss_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .timing(timing),
    .req_valid(req_valid), .req_rd(req_rd), .req_wdata(req_wdata),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_ready(req_ready),
    .dq_in(nand_dq_in), .phase(phase),
    .acc_rd(acc_rd), .acc_cmd(acc_cmd), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .acc_start(acc_start), .strobe_last(strobe_last), .turn_done(turn_done)
  );

  nss_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .phase(phase), .acc_rd(acc_rd), .acc_cmd(acc_cmd), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .sel_n(nand_sel_n), .rd_n(nand_rd_n), .wr_n(nand_wr_n),
    .cmd_latch(nand_cmd_latch), .addr_latch(nand_addr_latch),
    .dq_oe(nand_dq_oe), .dq_out(nand_dq_out)
  );

  nss_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
    .clk(clk), .rst_n(rst_n), .d(nand_rb), .q(stat_ready)
  );

endmodule

// File: rtl/nss_checker.sv
module nss_checker #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic nand_sel_n,
  input logic nand_rd_n,
  input logic nand_wr_n,
  input logic nand_cmd_latch,
  input logic nand_addr_latch,
  input logic nand_dq_oe,
  input logic rsp_valid,
  input logic nand_rb,
  input logic stat_ready,
  input logic acc_start,
  input logic strobe_last,
  input logic turn_done
);

  a_r4_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_rd_n || !nand_wr_n) |-> !nand_sel_n);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_rd_n && !nand_wr_n));

  a_r3_setup_has_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> (!nand_sel_n && nand_rd_n && nand_wr_n));

  a_r6_one_qualifier: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cmd_latch && nand_addr_latch));

  a_r6_qualifier_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cmd_latch || nand_addr_latch) |-> !nand_sel_n);

  a_r7_drive_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> (!nand_sel_n && nand_rd_n));

  a_r5_rsp_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(strobe_last) && nand_rd_n && !nand_sel_n));

  a_r8_ready_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_sel_n && !nand_dq_oe));

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_ready_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    turn_done |=> req_ready);

  generate
    if (SYNC_STAGES >= 2) begin : g_sync_chk
      a_r9_rise_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_ready) |-> $past(nand_rb));
    end
  endgenerate

endmodule

bind nand_strobe_seq nss_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .nand_sel_n(nand_sel_n), .nand_rd_n(nand_rd_n), .nand_wr_n(nand_wr_n),
  .nand_cmd_latch(nand_cmd_latch), .nand_addr_latch(nand_addr_latch),
  .nand_dq_oe(nand_dq_oe), .rsp_valid(rsp_valid), .nand_rb(nand_rb),
  .stat_ready(stat_ready), .acc_start(acc_start), .strobe_last(strobe_last),
  .turn_done(turn_done)
);

// File: tb/sim_nand_strobe_seq.sv
module sim_nand_strobe_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_rd = 1'b0, req_cmd = 1'b0, req_addr = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata, nand_dq_out;
  logic        nand_sel_n, nand_rd_n, nand_wr_n, nand_cmd_latch, nand_addr_latch, nand_dq_oe;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb = 1'b0;
  logic        stat_ready;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  nand_strobe_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_rd(req_rd),
    .req_wdata(req_wdata), .req_cmd(req_cmd), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .nand_sel_n(nand_sel_n), .nand_rd_n(nand_rd_n), .nand_wr_n(nand_wr_n),
    .nand_cmd_latch(nand_cmd_latch), .nand_addr_latch(nand_addr_latch),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
    .nand_rb(nand_rb), .stat_ready(stat_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Timing word assembled by arithmetic weights, independent of the RTL slicing.
  function automatic logic [31:0] mk_word(int ws, int wt, int wh, int rs, int rt, int rh, int g);
    return 32'(ws * 67108864 + wt * 1048576 + wh * 131072 +
               rs * 8192 + rt * 128 + rh * 16 + g * 4);
  endfunction

  task automatic set_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One access; s/t/h are the fields for its direction, g the gap.
  task automatic run_access(input logic rd, input logic cmd, input logic adr,
                            input logic [7:0] d, input int s, input int t,
                            input int h, input int g);
    int win_len, last;
    logic win, stb;
    @(negedge clk);
    chk("R8 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_rd = rd; req_cmd = cmd; req_addr = adr;
    req_wdata = d; nand_dq_in = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~d;
    win_len = s + t + h + 3;
    last = win_len + g + 1;
    for (int c = 0; c <= last; c++) begin
      if (c > 0) @(negedge clk);
      win = (c < win_len);
      stb = (c >= s + 1) && (c <= s + t + 1);
      chk("R4 select", 32'(nand_sel_n), 32'(!win));
      chk("R3 R4 read strobe", 32'(nand_rd_n), 32'(!(rd && stb)));
      chk("R3 R4 write strobe", 32'(nand_wr_n), 32'(!(!rd && stb)));
      chk("R6 command qualifier", 32'(nand_cmd_latch), 32'(win && cmd));
      chk("R6 address qualifier", 32'(nand_addr_latch), 32'(win && adr && !cmd));
      chk("R7 bus enable", 32'(nand_dq_oe), 32'(win && !rd));
      chk("R7 bus value", 32'(nand_dq_out), (win && !rd) ? 32'(d) : 32'd0);
      chk("R8 request ready", 32'(req_ready), 32'(c == last));
      chk("R5 response valid", 32'(rsp_valid), 32'(rd && (c == s + t + 2)));
      if (rd && (c == s + t + 2)) chk("R5 read byte", 32'(rsp_rdata), 32'(d));
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk("R1 ready in reset", 32'(req_ready), 32'd1);
    chk("R1 select in reset", 32'(nand_sel_n), 32'd1);
    chk("R1 strobes in reset", 32'({nand_rd_n, nand_wr_n}), 32'd3);
    chk("R1 qualifiers in reset", 32'({nand_cmd_latch, nand_addr_latch}), 32'd0);
    chk("R1 bus in reset", 32'(nand_dq_oe), 32'd0);
    chk("R1 response in reset", 32'(rsp_valid), 32'd0);
    chk("R1 status in reset", 32'(stat_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 select after reset", 32'(nand_sel_n), 32'd1);

    // R2: reset word gives write 1/3/1, read 1/5/1, gap 3
    run_access(1'b0, 1'b1, 1'b0, 8'h70, 1, 3, 1, 3);
    run_access(1'b1, 1'b0, 1'b0, 8'hA5, 1, 5, 1, 3);

    // R3..R8 sweep; read fields differ from write fields
    idx = 0;
    for (int s = 0; s <= 2; s++)
      for (int t = 0; t <= 2; t++)
        for (int h = 0; h <= 1; h++)
          for (int g = 0; g <= 3; g++) begin
            set_cfg(mk_word(s, t, h, t, s + 1, 1 - h, g));
            run_access(1'b0, idx[0], idx[1], 8'(idx * 37 + 1), s, t, h, g);
            run_access(1'b1, idx[1], idx[0], 8'(idx * 53 + 9), t, s + 1, 1 - h, g);
            idx++;
          end

    // R10: control and bus-size bits set, timing unchanged
    set_cfg(mk_word(2, 1, 0, 0, 2, 1, 1) | 32'hC000_0003);
    run_access(1'b0, 1'b0, 1'b1, 8'h3C, 2, 1, 0, 1);
    run_access(1'b1, 1'b1, 1'b1, 8'hC3, 0, 2, 1, 1);

    // R3 boundary: every field at its maximum
    set_cfg(mk_word(15, 63, 7, 15, 63, 7, 3));
    run_access(1'b0, 1'b1, 1'b1, 8'hFF, 15, 63, 7, 3);
    run_access(1'b1, 1'b0, 1'b1, 8'h00, 15, 63, 7, 3);

    // R9: two-edge synchronisation of the ready line
    @(negedge clk); nand_rb = 1'b1;
    @(negedge clk); chk("R9 ready after one edge", 32'(stat_ready), 32'd0);
    @(negedge clk); chk("R9 ready after two edges", 32'(stat_ready), 32'd1);
    nand_rb = 1'b0;
    @(negedge clk); chk("R9 busy after one edge", 32'(stat_ready), 32'd1);
    @(negedge clk); chk("R9 busy after two edges", 32'(stat_ready), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule